// File: doc/BRIEF.md
# Switch-Enable Register Target on a Two-Wire Serial Bus

This block is a small I2C target that holds a single 8-bit word. Each bit of the word drives the enable line of one switch channel. A controller writes the word with one address byte followed by one data byte. It reads the word back with one address byte, after which the target sends the byte. There is no register sub-address: the byte that follows the address is the switch word itself.

Both bus lines come in through reset-to-high synchronizers. The protocol engine detects edges on the synchronized lines, finds START and STOP, and runs a byte-level state machine. The 7-bit target address has two parts:
- the upper five bits, a fixed parameter, so that two device variants can share the design;
- the lower two bits, taken from strap inputs.

SDA is open drain. The block only asserts a pull-down enable.

States and their transitions:
- `ST_IDLE` leaves only on a START.
- `ST_ADDR` shifts eight bits. It goes to `ST_ADDR_ACK` on an address hit, or to `ST_IGNORE` on a miss.
- `ST_ADDR_ACK` holds the acknowledge and then branches on the R/W bit to `ST_WR_DATA` or `ST_RD_DATA`.
- `ST_WR_DATA` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` commits the register and goes to `ST_IGNORE`.
- `ST_RD_DATA` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` samples the controller's answer and goes to `ST_IGNORE`.
- From any state, a START leads to `ST_ADDR` and a STOP leads to `ST_IDLE`.

Top module: `swctl_i2c_target`

## Requirements
- R1: After reset `sw_en_o` is 8'h00 and `sda_pull_o` is 0.
- R2: A START (SDA falling while SCL is high) begins an address phase. A STOP (SDA rising while SCL is high) returns the block to idle. Bits clocked after a STOP without a new START are never acknowledged.
- R3: The address byte is sent MSB first. It is the 7-bit address {ADDR_HI[4:0], strap_i[1], strap_i[0]} followed by the R/W bit (0 = write, 1 = read). On a match the target pulls SDA low for the whole ninth clock.
- R4: On a non-matching address the target never pulls SDA until the next START, and the register is unchanged.
- R5: In a write, one data byte follows, MSB first. The target acknowledges it. Data bit k drives `sw_en_o[k]` (bit 7 to channel 8, bit 0 to channel 1).
- R6: `sw_en_o` keeps its old value through the data acknowledge clock. It takes the new value only after the falling SCL edge that ends that clock.
- R7: In a read, after the address acknowledge the target puts the current register on SDA, MSB first, one bit per clock. It then releases SDA for the controller's NO ACK clock.
- R8: A START in the middle of a byte abandons it. The partial byte is discarded, and the next address phase works normally.
- R9: `sda_pull_o` changes only while SCL is low.
- R10: A second data byte in a write is neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| strap_i | input | 2 | Low two address bits from strap pins |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| sw_en_o | output | 8 | Switch-channel enables; bit k drives channel k+1 |

## Verification
The register commit and the release of the data acknowledge are triggered by the same falling SCL edge. Each is checked on its own:
- during the ninth clock's high phase, the bench checks that SDA is held low while `sw_en_o` still shows the old word;
- a quarter bit later, it checks that SDA is free and the new word is present.

START detection also overrides whatever the byte counter would do in the cycle it is seen. To provoke this, the bench issues a START after four data bits. It then expects the old register value and a clean acknowledge of the following address.

// File: rtl/swctl_pkg.sv
package swctl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_IGNORE
    } swctl_state_e;
endpackage

// File: rtl/swctl_sync.sv
module swctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/swctl_proto.sv
module swctl_proto
    import swctl_pkg::*;
#(
    parameter int           AHI_W   = 5,
    parameter logic [AHI_W-1:0] ADDR_HI = 5'b10011,
    parameter int           NCH     = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_s,
    input  logic           sda_s,
    input  logic [1:0]     strap_i,
    output logic           pull_o,
    output logic [NCH-1:0] reg_o
);
    localparam int CW = $clog2(NCH + 1);

    swctl_state_e   state_q, state_d;
    logic           scl_q, sda_q;
    logic [CW-1:0]  cnt_q;
    logic [NCH-1:0] sh_q, tx_q, reg_q;
    logic           pull_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det, byte_done, addr_hit;
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
    assign byte_done = (cnt_q == CW'(NCH));
    assign addr_hit  = (sh_q[NCH-1:1] == {ADDR_HI, strap_i});

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det)
            state_d = ST_ADDR;
        else if (stop_det)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE, ST_IGNORE: state_d = state_q;
                ST_ADDR:     if (scl_fall && byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall) state_d = sh_q[0] ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) state_d = ST_IGNORE;
                ST_RD_DATA:  if (scl_fall && byte_done) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_rise) state_d = ST_IGNORE;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            tx_q   <= '0;
            reg_q  <= '0;
            pull_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q  <= '0;
            pull_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise) begin
                        sh_q  <= {sh_q[NCH-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (scl_fall && byte_done) begin
                        cnt_q  <= '0;
                        pull_q <= (state_q == ST_WR_DATA) || addr_hit;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (sh_q[0]) begin
                            tx_q   <= reg_q;
                            pull_q <= ~reg_q[NCH-1];
                        end else begin
                            pull_q <= 1'b0;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) begin
                        reg_q  <= sh_q;
                        pull_q <= 1'b0;
                    end
                end
                ST_RD_DATA: begin
                    if (scl_rise) cnt_q <= cnt_q + 1'b1;
                    if (scl_fall) begin
                        if (byte_done) begin
                            cnt_q  <= '0;
                            pull_q <= 1'b0;
                        end else begin
                            tx_q   <= {tx_q[NCH-2:0], 1'b0};
                            pull_q <= ~tx_q[NCH-2];
                        end
                    end
                end
                ST_IDLE, ST_RD_ACK, ST_IGNORE: cnt_q <= cnt_q;
                default: cnt_q <= '0;
            endcase
        end
    end

    assign pull_o = pull_q;
    assign reg_o  = reg_q;

    // R9: pull-down moves only after SCL was seen low
    p_pull_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pull_q) |-> !$past(scl_s));

    // R6: register changes only out of the write acknowledge state
    p_commit_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_q) |-> ($past(state_q) == ST_WR_ACK));

    // R4: no pull while ignoring or idle
    p_quiet_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE || state_q == ST_IDLE) |-> !pull_q);

    // R8: a START always restarts the address phase
    p_start_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && cnt_q == '0));

    // R3: bit counter never passes one byte
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(NCH));
endmodule

// File: rtl/swctl_i2c_target.sv
module swctl_i2c_target #(
    parameter int               AHI_W       = 5,
    parameter logic [AHI_W-1:0] ADDR_HI     = 5'b10011,
    parameter int               NCH         = 8,
    parameter int               SYNC_STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           scl_i,
    input  logic           sda_i,
    input  logic [1:0]     strap_i,
    output logic           sda_pull_o,
    output logic [NCH-1:0] sw_en_o
);
    logic [1:0] raw_w, syn_w;
    assign raw_w = {sda_i, scl_i};

    for (genvar g = 0; g < 2; g++) begin : g_sync
        swctl_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_w[g]),
            .dout (syn_w[g])
        );
    end

    swctl_proto #(
        .AHI_W  (AHI_W),
        .ADDR_HI(ADDR_HI),
        .NCH    (NCH)
    ) proto_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_s  (syn_w[0]),
        .sda_s  (syn_w[1]),
        .strap_i(strap_i),
        .pull_o (sda_pull_o),
        .reg_o  (sw_en_o)
    );
endmodule

// File: tb/swctl_i2c_target_tb_top.sv
module swctl_i2c_target_tb_top;
    localparam int Q = 10;
    localparam logic [4:0] AHI = 5'b10011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       ctl_low = 1'b0;
    logic [1:0] strap = 2'b10;
    logic       pull;
    logic [7:0] sw_en;
    logic       sda_bus;

    assign sda_bus = ~(ctl_low | pull);

    always #4 clk = ~clk;

    swctl_i2c_target dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl),
        .sda_i     (sda_bus),
        .strap_i   (strap),
        .sda_pull_o(pull),
        .sw_en_o   (sw_en)
    );

    int errors = 0;
    int checks = 0;
    int r9_viol = 0;
    bit pull_any = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] got_byte;
    event rd_ev;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // R9 monitor on the raw bus clock
    always @(pull) begin
        if (pull) pull_any = 1;
        if (rst_n && scl) r9_viol++;
    end

    // scoreboard monitor for read bytes (R7)
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) check("R7 unexpected read", 32'(got_byte), 32'hx);
            else check("R7 read byte", 32'(got_byte), 32'(exp_q.pop_front()));
        end
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bit_tx(input logic b, output logic smp);
        ctl_low = ~b; wq();
        scl = 1'b1;   wq();
        smp = sda_bus; wq();
        scl = 1'b0;   wq();
    endtask

    task automatic start_c();
        ctl_low = 1'b0; wq();
        scl = 1'b1;     wq();
        ctl_low = 1'b1; wq();
        scl = 1'b0;     wq();
    endtask

    task automatic stop_c();
        ctl_low = 1'b1; wq();
        scl = 1'b1;     wq();
        ctl_low = 1'b0; wq();
    endtask

    task automatic byte_tx(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_tx(b[i], s);
        bit_tx(1'b1, ack);
    endtask

    task automatic wr_txn(input logic [6:0] a, input logic [7:0] d, output logic aa, output logic da);
        start_c();
        byte_tx({a, 1'b0}, aa);
        byte_tx(d, da);
        stop_c();
    endtask

    task automatic rd_txn(input logic [6:0] a, input logic [7:0] exp);
        logic aa, s;
        exp_q.push_back(exp);
        start_c();
        byte_tx({a, 1'b1}, aa);
        check("R3 read address ack", 32'(aa), 32'h0);
        for (int i = 7; i >= 0; i--) bit_tx(1'b1, got_byte[i]);
        ->rd_ev;
        bit_tx(1'b1, s);
        check("R7 SDA released for NO ACK", 32'(s), 32'h1);
        stop_c();
    endtask

    initial begin
        logic aa, da, s;
        logic [6:0] adr;
        adr = {AHI, 2'b10};
        repeat (5) @(negedge clk);
        check("R1 reset sw_en", 32'(sw_en), 32'h0);
        check("R1 reset pull", 32'(pull), 32'h0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R5/R6: write with inline acknowledge check
        start_c();
        byte_tx({adr, 1'b0}, aa);
        check("R3 write address ack", 32'(aa), 32'h0);
        for (int i = 7; i >= 0; i--) bit_tx(8'hA5 >> i, s);
        ctl_low = 1'b0; wq();
        scl = 1'b1; wq();
        check("R5 data ack", 32'(sda_bus), 32'h0);
        check("R6 sw_en held during ack clock", 32'(sw_en), 32'h00);
        wq();
        scl = 1'b0; wq();
        check("R6 sw_en after ack clock", 32'(sw_en), 32'hA5);
        check("R6 SDA released after ack", 32'(sda_bus), 32'h1);
        stop_c();

        rd_txn(adr, 8'hA5);

        // R4: wrong strap bits in address
        pull_any = 0;
        wr_txn({AHI, 2'b01}, 8'h3C, aa, da);
        check("R4 miss address no ack", 32'(aa), 32'h1);
        check("R4 miss data no ack", 32'(da), 32'h1);
        check("R4 no pull seen", 32'(pull_any), 32'h0);
        check("R4 register unchanged", 32'(sw_en), 32'hA5);

        // R10: second data byte
        start_c();
        byte_tx({adr, 1'b0}, aa);
        byte_tx(8'h81, da);
        check("R10 first byte ack", 32'(da), 32'h0);
        byte_tx(8'hFF, da);
        check("R10 second byte no ack", 32'(da), 32'h1);
        stop_c();
        check("R10 register keeps first byte", 32'(sw_en), 32'h81);

        // R2: address without START after a STOP
        byte_tx({adr, 1'b0}, aa);
        check("R2 no ack without START", 32'(aa), 32'h1);
        stop_c();

        // R8: START after four data bits
        start_c();
        byte_tx({adr, 1'b0}, aa);
        for (int i = 0; i < 4; i++) bit_tx(1'b0, s);
        start_c();
        check("R8 partial byte discarded", 32'(sw_en), 32'h81);
        byte_tx({adr, 1'b0}, aa);
        check("R8 address ack after restart", 32'(aa), 32'h0);
        byte_tx(8'h0F, da);
        stop_c();
        check("R8 write after restart", 32'(sw_en), 32'h0F);

        // R3: other strap setting, extreme patterns
        strap = 2'b01;
        adr = {AHI, 2'b01};
        wr_txn(adr, 8'hFF, aa, da);
        check("R3 strap 01 ack", 32'(aa), 32'h0);
        check("R5 all channels on", 32'(sw_en), 32'hFF);
        rd_txn(adr, 8'hFF);
        wr_txn(adr, 8'h00, aa, da);
        check("R5 all channels off", 32'(sw_en), 32'h00);
        rd_txn(adr, 8'h00);
        wr_txn(adr, 8'h01, aa, da);
        check("R5 bit0 drives channel 1", 32'(sw_en), 32'h01);
        rd_txn(adr, 8'h01);

        check("R9 pull changes only with SCL low", 32'(r9_viol), 32'h0);
        repeat (20) @(negedge clk);
        check("R7 all reads compared", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule